// File: doc/BRIEF.md
# Restricted-Range Decimal Digit Multiplier Array

This block forms one decimal partial product in a single registered step. It takes a recoded multiplicand of NDIG+1 signed-magnitude digits and one recoded multiplier digit. Every digit lies in −5..+5, and the top multiplicand digit lies in −1..+1. For each multiplicand position it produces a two-digit product. The lower digit stays in that position and the upper digit weighs one decade more, so in the partial product that results, interior positions carry two overlapping digits.

Magnitudes of 0 and 1 skip the product logic. A zero gives a zero product, and a one passes the other magnitude through. Only magnitude pairs in 2..5 reach a small product function. That function writes each product as a non-negative upper digit in 0..2 plus a lower digit in −5..+5. The signs are applied afterwards. The XOR of the two input signs becomes the sign of the upper digit, and it is also XORed into the sign of the lower digit.

The block feeds a one-digit-per-cycle multiplier pipeline. Each accepted operand pair gives one registered result, marked by a valid flag, one cycle later.

Top module: `dec_digit_mult_array`

## Requirements
- R1: When either input magnitude is 0 at a position, both output magnitudes at that position are 0.
- R2: When a multiplicand magnitude is 1, that position's lower magnitude equals the multiplier magnitude and its upper magnitude is 0.
- R3: When the multiplier magnitude is 1, each full position's lower magnitude equals the multiplicand magnitude and its upper magnitude is 0.
- R4: For magnitudes a, b in 2..5 with p = a*b, the upper magnitude is u = floor((p+4)/10), which is always in 0..2. The lower digit is p − 10u, which is always in −5..+5.
- R5: The upper sign bit equals the XOR s of the two input signs. The lower sign bit equals s XOR (the lower value of R4 is negative).
- R6: Encoding. An input digit is 4 bits, with bit 3 the sign (1 = negative) and bits 2:0 the magnitude. Multiplicand digit k sits at bits 4k+3:4k. An upper output digit k is 3 bits at 3k+2:3k, with bit 2 the sign and bits 1:0 the magnitude, and it weighs 10^(k+1). A lower output digit k is 4 bits at 4k+3:4k, encoded like an input digit, and it weighs 10^k.
- R7: The top position NDIG has an upper magnitude of 0. Its lower magnitude is the multiplier magnitude if the top multiplicand magnitude is nonzero, and 0 otherwise.
- R8: The signed, weighted sum of all upper and lower digits equals the multiplicand value times the multiplier value.
- R9: Results and out_valid appear on the clock edge after in_valid is sampled high. Reset clears out_valid and all digits.
- R10: While in_valid is low, the outputs hold their values and out_valid goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands valid |
| mcand_sm | input | 4*(NDIG+1) | Recoded multiplicand digits |
| mplier_sm | input | 4 | Recoded multiplier digit |
| out_valid | output | 1 | Result valid |
| up_dig | output | 3*(NDIG+1) | Upper product digits |
| lo_dig | output | 4*(NDIG+1) | Lower product digits |

## Verification
Every product digit and the valid flag pass through exactly one register, so all results are due on the first rising edge after the operands are sampled. The bench drives the operands on a falling edge and clears in_valid on the next falling edge. It reads the outputs at that same falling edge, which is half a cycle after the edge that loaded them. The hold checks change the inputs with in_valid low and read one falling edge later. This confirms that the edge in between left the outputs untouched.

// File: rtl/dec_digit_mult_array.sv
module dec_digit_mult_array #(
  parameter int NDIG = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [4*NDIG+3:0]     mcand_sm,
  input  logic [3:0]            mplier_sm,
  output logic                  out_valid,
  output logic [3*NDIG+2:0]     up_dig,
  output logic [4*NDIG+3:0]     lo_dig
);
  localparam int POS = NDIG + 1;

  logic [3*POS-1:0] up_c;
  logic [4*POS-1:0] lo_c;

  wire       b_sgn = mplier_sm[3];
  wire [2:0] b_mag = mplier_sm[2:0];

  for (genvar k = 0; k < NDIG; k++) begin : g_pos
    wire [2:0] a_mag = mcand_sm[4*k +: 3];
    wire       s     = mcand_sm[4*k+3] ^ b_sgn;
    wire [4:0] prod  = {2'b00, a_mag} * {2'b00, b_mag};
    logic [1:0] um;
    logic       tneg;
    logic [2:0] lm;

    always_comb begin
      um = 2'd0; tneg = 1'b0; lm = 3'd0;
      if (a_mag == 3'd0 || b_mag == 3'd0) begin
        lm = 3'd0;
      end else if (a_mag == 3'd1) begin
        lm = b_mag;
      end else if (b_mag == 3'd1) begin
        lm = a_mag;
      end else begin
        case (prod)
          5'd4:    begin um = 2'd0; lm = 3'd4; end
          5'd6:    begin um = 2'd1; lm = 3'd4; tneg = 1'b1; end
          5'd8:    begin um = 2'd1; lm = 3'd2; tneg = 1'b1; end
          5'd9:    begin um = 2'd1; lm = 3'd1; tneg = 1'b1; end
          5'd10:   begin um = 2'd1; lm = 3'd0; end
          5'd12:   begin um = 2'd1; lm = 3'd2; end
          5'd15:   begin um = 2'd1; lm = 3'd5; end
          5'd16:   begin um = 2'd2; lm = 3'd4; tneg = 1'b1; end
          5'd20:   begin um = 2'd2; lm = 3'd0; end
          5'd25:   begin um = 2'd2; lm = 3'd5; end
          default: begin um = 2'd0; lm = 3'd0; end
        endcase
      end
    end

    assign up_c[3*k +: 3] = {s, um};
    assign lo_c[4*k +: 4] = {s ^ tneg, lm};
  end

  wire top_s  = mcand_sm[4*NDIG+3] ^ b_sgn;
  wire top_nz = |mcand_sm[4*NDIG +: 3];
  assign up_c[3*NDIG +: 3] = {top_s, 2'b00};
  assign lo_c[4*NDIG +: 4] = {top_s, top_nz ? b_mag : 3'd0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      up_dig    <= '0;
      lo_dig    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        up_dig <= up_c;
        lo_dig <= lo_c;
      end
    end
  end
endmodule

// File: rtl/dec_digit_mult_array_chk.sv
module dec_digit_mult_array_chk #(
  parameter int NDIG = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [4*NDIG+3:0] mcand_sm,
  input logic [3:0]        mplier_sm,
  input logic              out_valid,
  input logic [3*NDIG+2:0] up_dig,
  input logic [4*NDIG+3:0] lo_dig
);
  function automatic logic up_ok(input logic [3*NDIG+2:0] v);
    up_ok = 1'b1;
    for (int k = 0; k <= NDIG; k++) if (v[3*k +: 2] == 2'd3) up_ok = 1'b0;
  endfunction

  function automatic logic lo_ok(input logic [4*NDIG+3:0] v);
    lo_ok = 1'b1;
    for (int k = 0; k <= NDIG; k++) if (v[4*k +: 3] > 3'd5) lo_ok = 1'b0;
  endfunction

  function automatic logic all_zero_mag(input logic [3*NDIG+2:0] u, input logic [4*NDIG+3:0] l);
    all_zero_mag = 1'b1;
    for (int k = 0; k <= NDIG; k++)
      if (u[3*k +: 2] != 2'd0 || l[4*k +: 3] != 3'd0) all_zero_mag = 1'b0;
  endfunction

  assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(up_dig) && $stable(lo_dig)));
  assert_up_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> up_ok(up_dig));
  assert_lo_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> lo_ok(lo_dig));
  assert_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mplier_sm[2:0] == 3'd0) |=> all_zero_mag(up_dig, lo_dig));
  assert_up_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (up_dig[2] == $past(mcand_sm[3] ^ mplier_sm[3])));
  assert_top_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (up_dig[3*NDIG +: 2] == 2'd0));
endmodule

bind dec_digit_mult_array dec_digit_mult_array_chk #(.NDIG(NDIG)) u_chk (.*);

// File: tb/tb_dec_digit_mult_array.sv
`timescale 1ns/1ps
module tb_dec_digit_mult_array;
  localparam int NDIG = 4;
  localparam int POS  = NDIG + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [4*POS-1:0] mcand_sm = '0;
  logic [3:0] mplier_sm = '0;
  logic out_valid;
  logic [3*POS-1:0] up_dig;
  logic [4*POS-1:0] lo_dig;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  dec_digit_mult_array #(.NDIG(NDIG)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .mcand_sm(mcand_sm), .mplier_sm(mplier_sm),
    .out_valid(out_valid), .up_dig(up_dig), .lo_dig(lo_dig));

  // {multiplicand digits MSD..LSD, multiplier digit}, R6 encoding
  localparam logic [23:0] VEC [10] = '{
    24'h003415, 24'h15C2AD, 24'h1DDDDD, 24'h055552, 24'h0ABCD4,
    24'h12345B, 24'h000005, 24'h199990, 24'h043211, 24'h1C0B39 };

  function automatic longint sv4(input logic [3:0] v);
    return v[3] ? -longint'(v[2:0]) : longint'(v[2:0]);
  endfunction
  function automatic longint sv3(input logic [2:0] v);
    return v[2] ? -longint'(v[1:0]) : longint'(v[1:0]);
  endfunction

  // expected {upper3, lower4} for one position, from R1..R5, R7
  function automatic logic [6:0] exp_pos(input logic [3:0] a, input logic [3:0] b, input bit top);
    int am, bm, p, u, l;
    logic s;
    am = int'(a[2:0]); bm = int'(b[2:0]); s = a[3] ^ b[3];
    if (top) return {s, 2'b00, s, (am != 0) ? b[2:0] : 3'd0};
    p = am * bm;
    if (am <= 1 || bm <= 1) begin u = 0; l = p; end
    else begin u = (p + 4) / 10; l = p - 10 * u; end
    return {s, 2'(u), s ^ (l < 0), 3'((l < 0) ? -l : l)};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [4*POS-1:0] mc, input logic [3:0] mp);
    @(negedge clk);
    mcand_sm = mc; mplier_sm = mp; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_all(input string req);
    logic [6:0] e;
    longint sum, opv, w;
    chk({req, " R9 out_valid"}, longint'(out_valid), 1);
    sum = 0; opv = 0; w = 1;
    for (int k = 0; k < POS; k++) begin
      e = exp_pos(mcand_sm[4*k +: 4], mplier_sm, k == NDIG);
      chk({req, $sformatf(" pos%0d", k)}, longint'({up_dig[3*k +: 3], lo_dig[4*k +: 4]}), longint'(e));
      sum += sv4(lo_dig[4*k +: 4]) * w + sv3(up_dig[3*k +: 3]) * w * 10;
      opv += sv4(mcand_sm[4*k +: 4]) * w;
      w *= 10;
    end
    chk("R8 weighted sum", sum, opv * sv4(mplier_sm));
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [3*POS-1:0] hu;
    logic [4*POS-1:0] hl;
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", longint'(out_valid), 0);
    chk("R9 reset up_dig", longint'(up_dig), 0);
    chk("R9 reset lo_dig", longint'(lo_dig), 0);
    rst_n = 1'b1;

    for (int v = 0; v < 10; v++) begin
      apply(VEC[v][23:4], VEC[v][3:0]);
      check_all("R8 vector");
    end

    // exhaustive position 0 (R1..R5)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        if (a[2:0] > 5 || b[2:0] > 5) continue;
        apply({16'h0000, 4'(a)}, 4'(b));
        if (a[2:0] == 0 || b[2:0] == 0) check_all("R1");
        else if (a[2:0] == 1) check_all("R2");
        else if (b[2:0] == 1) check_all("R3");
        else check_all("R4 R5");
      end
    end

    // top position, both signs (R7)
    apply(20'h9_0000, 4'h5);
    check_all("R7 top neg");
    apply(20'h1_0000, 4'hB);
    check_all("R7 top pos");

    // hold with in_valid low (R10)
    apply(20'h0_5432, 4'h4);
    hu = up_dig; hl = lo_dig;
    mcand_sm = 20'h1_DDDD; mplier_sm = 4'hD;
    @(negedge clk);
    chk("R10 hold out_valid", longint'(out_valid), 0);
    chk("R10 hold up_dig", longint'(up_dig), longint'(hu));
    chk("R10 hold lo_dig", longint'(lo_dig), longint'(hl));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule